// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a 32-bit synchronous static memory with a pipelined read path and a built-in four-beat burst sequencer. Every control, address and data input is captured on the rising clock edge. A burst opens when one of two address strobes is seen active. The first strobe belongs to the processor side and only counts while the primary chip enable is asserted. The second strobe belongs to the controller side and always counts. On later cycles the burst-advance input steps a two-bit beat counter. The counter replaces only the two lowest address bits and wraps after four beats.

Writes use a byte-lane mask. A global-write input forces all four lanes on. The per-lane enables count only while the byte-write enable is active. Read data is registered one cycle after the address. It reaches the pins through an asynchronous, active-low output enable. A drive-enable output tells the surrounding pad logic when the data bus is driven. The storage depth is a parameter, so a small array can stand in for the full 17-bit, 131,072-word space during test.

Top module: `burst_sram`

## Requirements
- R1: A read registered at clock edge k shows its word on `dOut`, with `dqDrive` high, from edge k until edge k+1, as long as `oeN` is low.
- R2: `dqDrive` is low (and `dOut` is high-impedance) in four cases: while `oeN` is high, after reset, after a cycle that wrote, and after a cycle that did no access.
- R3: With `mode` low the burst offset is (start offset + beat) mod 4, with beat counting 0,1,2,3. The upper address bits stay fixed. A fifth advance returns to the start offset.
- R4: With `mode` high the burst offset is start offset XOR beat.
- R5: A non-strobe cycle with `advN` high accesses the same address as the previous cycle.
- R6: With `gwN` high and `bweN` low, `bwN[i]` low writes data bits 8i+7:8i and leaves the other lanes unchanged. With `gwN` and `bweN` both high, nothing is written and the cycle is a read.
- R7: `gwN` low writes all four bytes, whatever `bwN` and `bweN` hold.
- R8: `adspN` low is ignored while `ceN` is high. `adscN` low always opens a burst at `addr`.
- R9: When both strobes are low in one cycle, `adspN` wins and the cycle is a read, even if write enables are active.
- R10: A strobe seen while any of `ceN` high, `ce2N` high or `ce2` low deselects the block. Later non-strobe cycles neither write nor drive data until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset of control and output state |
| ceN | input | 1 | Primary chip enable, active low; also gates `adspN` |
| ce2N | input | 1 | Depth-expansion enable, active low |
| ce2 | input | 1 | Depth-expansion enable, active high |
| adspN | input | 1 | Processor-side address strobe, active low |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Per-lane write enables, active low; bit i covers data bits 8i+7:8i |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear (asynchronous) |
| oeN | input | 1 | Output enable, active low (asynchronous) |
| addr | input | 17 | Word address |
| dIn | input | 32 | Write data |
| dOut | output | 32 | Read data, high-impedance when not driven |
| dqDrive | output | 1 | High while `dOut` is driven |

## Verification
The burst sequencer is exercised three ways. A linear burst starts mid-block and runs past four beats, which exposes any wrap or carry error. An interleaved burst starts at an odd offset, where XOR and addition give different orders. A suspended beat with the advance input high checks that the counter holds. Write qualification is tested with a sparse lane mask and then read back, so a mis-mapped lane or a wrongly gated byte-write enable becomes visible. Global write is then used with the lane enables off. The strobe rules are driven with contrasting patterns: a gated processor strobe, both strobes together with writes requested, and a deselecting strobe followed by a write attempt. Each pattern reads back an address whose old contents tell the two possible behaviours apart.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int LANES = 4;

  // Per-cycle command from control to datapath
  typedef struct packed {
    logic             load;      // take a new start address this edge
    logic             advance;   // step beat counter this edge
    logic             wrEn;      // write selected lanes this edge
    logic             rdEn;      // capture read word this edge
    logic [LANES-1:0] byteMask;  // lanes to write
  } strobe_t;

  // Burst offset for a given start offset and beat number
  function automatic logic [1:0] burstOfs(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             ce2N,
  input  logic             ce2,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  output strobe_t          str
);

  logic selected;
  logic procStart, ctrlStart, anyStart, chipOn, active;
  logic [LANES-1:0] mask;

  always_comb begin
    procStart = !adspN && !ceN;
    ctrlStart = !adscN && !procStart;
    anyStart  = procStart || ctrlStart;
    chipOn    = !ceN && !ce2N && ce2;
    active    = anyStart ? chipOn : selected;

    if (!gwN)       mask = '1;
    else if (!bweN) mask = ~bwN;
    else            mask = '0;

    str.load     = anyStart;
    str.advance  = !anyStart && !advN && selected;
    str.byteMask = mask;
    str.wrEn     = active && !procStart && (mask != '0);
    str.rdEn     = active && !str.wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         selected <= 1'b0;
    else if (anyStart) selected <= chipOn;
  end

  AST_PROC_STROBE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !ceN) |-> !str.wrEn); // R9
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (!gwN && str.wrEn) |-> (str.byteMask == '1)); // R7
  AST_LANES_NEED_BWE: assert property (@(posedge clk) disable iff (!rstN)
    (gwN && bweN) |-> !str.wrEn); // R6
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!str.load && $past(str.load) && !$past(chipOn)) |-> !(str.rdEn || str.wrEn)); // R10
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(str.rdEn && str.wrEn)); // R1

endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 6,
  parameter int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic              mode,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dqDrive
);

  localparam int DEPTH  = 1 << MEM_AW;
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] baseAddr, nextBase, target;
  logic [1:0]        beat, nextBeat;
  logic [MEM_AW-1:0] memIdx;
  logic [DATA_W-1:0] rdWord, rdReg;
  logic              rdValid;

  always_comb begin
    nextBase = str.load ? addr : baseAddr;
    if (str.load)         nextBeat = 2'd0;
    else if (str.advance) nextBeat = beat + 2'd1;
    else                  nextBeat = beat;
    target = {nextBase[ADDR_W-1:2], burstOfs(nextBase[1:0], nextBeat, mode)};
    memIdx = target[MEM_AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beat     <= '0;
    end else begin
      baseAddr <= nextBase;
      beat     <= nextBeat;
    end
  end

  // One storage array per byte lane
  for (genvar b = 0; b < LANES; b++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (str.wrEn && str.byteMask[b])
        laneMem[memIdx] <= dIn[b*LANE_W +: LANE_W];
    end
    assign rdWord[b*LANE_W +: LANE_W] = laneMem[memIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= str.rdEn;
      if (str.rdEn) rdReg <= rdWord;
    end
  end

  assign dqDrive = rdValid && !oeN;
  assign dOut    = dqDrive ? rdReg : 'z;

  AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    str.rdEn |=> rdValid); // R1
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEn |=> !dqDrive); // R2
  AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (str.advance && beat == 2'd3) |=> (beat == 2'd0)); // R3
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!str.load && !str.advance) |=> $stable(beat) && $stable(baseAddr)); // R5

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 6,
  parameter int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              ce2N,
  input  logic              ce2,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              mode,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dqDrive
);

  strobe_t str;

  burst_sram_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .ce2N(ce2N), .ce2(ce2),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .str(str)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .mode(mode), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dqDrive(dqDrive)
  );

  AST_GATED_PROC_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && ceN && adscN) |-> !str.load); // R8
  AST_CTRL_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    !adscN |-> str.load); // R8

endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, ce2N = 1'b0, ce2 = 1'b1;
  logic        adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic        gwN = 1'b1, bweN = 1'b1, mode = 1'b0, oeN = 1'b0;
  logic [3:0]  bwN = 4'hF;
  logic [16:0] addr = '0;
  logic [31:0] dIn = '0;
  logic [31:0] dOut;
  logic        dqDrive;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rstN(rstN), .ceN(ceN), .ce2N(ce2N), .ce2(ce2),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .mode(mode), .oeN(oeN), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dqDrive(dqDrive)
  );

  typedef struct packed {
    logic        adsp, adsc, adv, ce, gw, bwe;
    logic [3:0]  bw;
    logic        md;
    logic [7:0]  ad;
    logic [31:0] din;
    logic        expZ;
    logic [31:0] expD;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1,0,1,0,0,1,4'hF,0,8'h10,32'h11110000,1,32'h0,4'd7},        // R7 global write, start 0x10
    '{1,1,0,0,0,1,4'hF,0,8'h00,32'h11110001,1,32'h0,4'd3},        // R3 beat1 -> 0x11
    '{1,1,0,0,0,1,4'hF,0,8'h00,32'h11110002,1,32'h0,4'd3},        // R3 -> 0x12
    '{1,1,0,0,0,1,4'hF,0,8'h00,32'h11110003,1,32'h0,4'd3},        // R3 -> 0x13
    '{1,0,1,0,1,1,4'hF,0,8'h12,32'h0,0,32'h11110002,4'd1},        // R1 read start 0x12
    '{1,1,0,0,1,1,4'hF,0,8'h00,32'h0,0,32'h11110003,4'd3},        // R3 offset 3
    '{1,1,0,0,1,1,4'hF,0,8'h00,32'h0,0,32'h11110000,4'd3},        // R3 wrap to 0
    '{1,1,0,0,1,1,4'hF,0,8'h00,32'h0,0,32'h11110001,4'd3},        // R3 offset 1
    '{1,1,0,0,1,1,4'hF,0,8'h00,32'h0,0,32'h11110002,4'd3},        // R3 fifth beat = start
    '{0,1,1,0,1,1,4'hF,1,8'h11,32'h0,0,32'h11110001,4'd4},        // R4 proc strobe 0x11
    '{1,1,0,0,1,1,4'hF,1,8'h00,32'h0,0,32'h11110000,4'd4},        // R4 1^1=0
    '{1,1,0,0,1,1,4'hF,1,8'h00,32'h0,0,32'h11110003,4'd4},        // R4 1^2=3
    '{1,1,0,0,1,1,4'hF,1,8'h00,32'h0,0,32'h11110002,4'd4},        // R4 1^3=2
    '{1,1,1,0,1,1,4'hF,1,8'h00,32'h0,0,32'h11110002,4'd5},        // R5 hold
    '{1,0,1,0,1,0,4'hA,0,8'h10,32'hAABBCCDD,1,32'h0,4'd6},        // R6 lanes 0,2
    '{1,1,1,0,1,1,4'hF,0,8'h00,32'h0,0,32'h11BB00DD,4'd6},        // R6 readback
    '{1,1,1,0,1,1,4'h0,0,8'h00,32'hFFFFFFFF,0,32'h11BB00DD,4'd6}, // R6 bwe off
    '{1,1,1,0,0,1,4'hF,0,8'h00,32'h55667788,1,32'h0,4'd7},        // R7 gw overrides
    '{1,1,1,0,1,1,4'hF,0,8'h00,32'h0,0,32'h55667788,4'd7},        // R7 readback
    '{0,1,1,1,1,1,4'hF,0,8'h13,32'h0,0,32'h55667788,4'd8},        // R8 gated proc strobe
    '{0,0,1,0,0,1,4'hF,0,8'h13,32'h0,0,32'h11110003,4'd9},        // R9 both strobes
    '{1,1,1,0,1,1,4'hF,0,8'h00,32'h0,0,32'h11110003,4'd9},        // R9 no write
    '{1,0,1,1,1,1,4'hF,0,8'h11,32'h0,1,32'h0,4'd10},              // R10 deselect
    '{1,1,0,0,0,1,4'hF,0,8'h00,32'h99999999,1,32'h0,4'd10},       // R10 write attempt
    '{1,0,1,0,1,1,4'hF,0,8'h12,32'h0,0,32'h11110002,4'd10}        // R10 0x12 untouched
  };

  task automatic chk(input int tag, input logic expZ, input logic [31:0] expD);
    total++;
    if (expZ ? dqDrive : (!dqDrive || dOut !== expD)) begin
      bad++;
      $display("FAIL R%0d: drive=%0b data=%h expected drive=%0b data=%h",
               tag, dqDrive, dOut, !expZ, expD);
    end
  endtask

  task automatic cyc(input logic sp, input logic sc, input logic av, input logic [16:0] a);
    @(negedge clk);
    adspN = sp; adscN = sc; advN = av; addr = a;
    gwN = 1'b1; bweN = 1'b1; bwN = 4'hF; ceN = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 chk(2, 1'b1, 32'h0);              // R2 reset state
    @(negedge clk) rstN = 1'b1;
    cyc(1, 1, 0, 17'h0);
    chk(10, 1'b1, 32'h0);                // R10 nothing selected after reset

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      adspN = TBL[i].adsp; adscN = TBL[i].adsc; advN = TBL[i].adv;
      ceN = TBL[i].ce; gwN = TBL[i].gw; bweN = TBL[i].bwe; bwN = TBL[i].bw;
      mode = TBL[i].md; addr = {9'h0, TBL[i].ad}; dIn = TBL[i].din;
      @(posedge clk); #2;
      chk(int'(TBL[i].tag), TBL[i].expZ, TBL[i].expD);
    end

    // R2 output enable is asynchronous
    cyc(1, 0, 1, 17'h10);
    chk(1, 1'b0, 32'h55667788);          // R1
    oeN = 1'b1; #1;
    chk(2, 1'b1, 32'h0);                 // R2 oe high
    oeN = 1'b0; #1;
    chk(2, 1'b0, 32'h55667788);          // R2 oe back low

    // R10 depth-expansion enables
    @(negedge clk) ce2 = 1'b0;
    cyc(1, 0, 1, 17'h10);
    chk(10, 1'b1, 32'h0);
    @(negedge clk) begin ce2 = 1'b1; ce2N = 1'b1; end
    cyc(1, 0, 1, 17'h10);
    chk(10, 1'b1, 32'h0);
    @(negedge clk) ce2N = 1'b0;
    cyc(1, 0, 1, 17'h13);
    chk(8, 1'b0, 32'h11110003);          // R8 controller strobe reselects

    // R2 reset clears drive
    @(negedge clk) rstN = 1'b0;
    #2 chk(2, 1'b1, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule